// File: doc/BRIEF.md
# Ethernet MAC Interrupt Status Aggregator

This block assembles the 32-bit read-only interrupt status word of an Ethernet MAC. It gathers event pulses and level summaries from the MAC's optional sub-features: general-purpose inputs, low-power idle, timestamping, the statistics counter module, power management, PCS auto-negotiation and link monitoring, and the parallel PHY interface link. It presents them as one status word at a fixed register offset and raises a single masked interrupt line.

The status word never clears itself when read. Each sticky bit is released only by a clear strobe. The surrounding register file pulses that strobe when software reads the sub-feature's own status register. The counter-module bits are not sticky. They follow the "any bit pending" state of their lower-level interrupt vectors, and a summary bit is the OR of them. Each feature can be removed by parameter, and the bit of a removed feature always reads 0.

Top module: `mac_irq_status`

## Requirements
- R1: After synchronous reset, `rd_data` and `irq` are 0, and a read of the status word returns 0.
- R2: A read with `rd_addr` equal to `REG_OFS` (default 0x38) loads `rd_data` with the status word on the next clock edge. A read of any other address loads 0. Bits 31:12 and bit 8 of `rd_data` are always 0.
- R3: Bit 11 sets when any `gpi_evt` bit is high while the matching `gpi_en` bit is high. An event whose enable is low has no effect. The bit holds until `gpi_clr`.
- R4: Bit 10 sets when any of the `LPI_N` lines of `lpi_evt` (entry or exit, transmit or receive) pulses, and clears on `lpi_clr`.
- R5: Bit 9 sets when any of the `TS_N` lines of `ts_evt` (target time reached, seconds overflow, auxiliary snapshot) pulses, and clears on `ts_clr`.
- R6: Bits 7, 6 and 5 are high exactly while `mmc_csum_pend`, `mmc_tx_pend` and `mmc_rx_pend` respectively have any bit set. Bit 4 is the OR of bits 7:5.
- R7: Bit 3 sets on `pmt_magic` or `pmt_wake`. Each cause is held separately, `pmt_clr` releases both, and bit 3 falls only when neither cause is held.
- R8: Bit 2 sets on `an_done` and bit 1 sets on `pcs_link_chg`. A single `an_clr` clears both.
- R9: Bit 0 sets in the cycle after `phy_link` differs from its previous value, and clears on `phy_clr`. The level of `phy_link` during reset is taken as the starting value.
- R10: When a set event and its clear strobe arrive in the same cycle, the bit ends at 1.
- R11: Reading the status word does not change any status bit.
- R12: The bit of a feature removed by its `HAS_*` parameter reads 0 and never raises `irq`.
- R13: `irq` is a register that, one clock after any status bit in 11:0 and the matching `irq_mask` bit are both 1, is 1, and is otherwise 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Registered read data |
| gpi_evt | input | GPI_N | General-purpose input event pulses |
| gpi_en | input | GPI_N | Per-input event enables |
| gpi_clr | input | 1 | Clear strobe for bit 11 |
| lpi_evt | input | LPI_N | Low-power-idle entry/exit pulses |
| lpi_clr | input | 1 | Clear strobe for bit 10 |
| ts_evt | input | TS_N | Timestamp event pulses |
| ts_clr | input | 1 | Clear strobe for bit 9 |
| mmc_rx_pend | input | MMC_W | Counter-module receive interrupt vector |
| mmc_tx_pend | input | MMC_W | Counter-module transmit interrupt vector |
| mmc_csum_pend | input | MMC_W | Counter-module receive-checksum interrupt vector |
| pmt_magic | input | 1 | Magic packet received in power-down |
| pmt_wake | input | 1 | Wake-up frame received in power-down |
| pmt_clr | input | 1 | Clear strobe for both power-management causes |
| an_done | input | 1 | PCS auto-negotiation complete pulse |
| pcs_link_chg | input | 1 | PCS link status change pulse |
| an_clr | input | 1 | Clear strobe for bits 2 and 1 |
| phy_link | input | 1 | Parallel PHY interface link status level |
| phy_clr | input | 1 | Clear strobe for bit 0 |
| irq_mask | input | 12 | Per-bit interrupt enables for bits 11:0 |
| irq | output | 1 | Registered combined interrupt |

## Verification
The bench builds two copies of the block from the same stimulus. One copy keeps every feature at its default of present. The other is built with the counter module, power management and PCS removed, so the reserved behaviour of absent bits can be compared against the full word on every read. The full build covers set, hold and clear ordering across all sources, including set-versus-clear collisions. The lean build shows that removed features stay at 0 on the read data and on the interrupt even when their events fire.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
  localparam int STAT_W = 32;
  localparam int USED_W = 12;

  // bit positions of the status word, decoded by software
  localparam int B_PHY   = 0;
  localparam int B_LCHG  = 1;
  localparam int B_ANC   = 2;
  localparam int B_PMT   = 3;
  localparam int B_MSUM  = 4;
  localparam int B_MRX   = 5;
  localparam int B_MTX   = 6;
  localparam int B_MCSUM = 7;
  localparam int B_TS    = 9;
  localparam int B_LPI   = 10;
  localparam int B_GPI   = 11;

  function automatic logic [STAT_W-1:0] feat_mask(
    input bit gpi, input bit lpi, input bit ts, input bit mmc,
    input bit csum, input bit pmt, input bit pcs, input bit phy);
    logic [STAT_W-1:0] m;
    m          = '0;
    m[B_GPI]   = gpi;
    m[B_LPI]   = lpi;
    m[B_TS]    = ts;
    m[B_MCSUM] = mmc & csum;
    m[B_MTX]   = mmc;
    m[B_MRX]   = mmc;
    m[B_MSUM]  = mmc;
    m[B_PMT]   = pmt;
    m[B_ANC]   = pcs;
    m[B_LCHG]  = pcs;
    m[B_PHY]   = phy;
    return m;
  endfunction
endpackage

// File: rtl/mac_irq_sticky.sv
module mac_irq_sticky #(
  parameter int SRC_W   = 1,
  parameter bit PRESENT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] set_vec,
  input  logic             clr,
  output logic             flag
);
  logic q;
  logic hit;

  assign hit = PRESENT && (|set_vec);

  // a set in the same cycle as a clear takes priority
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (hit) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  assign flag = q;
endmodule

// File: rtl/mac_irq_linkmon.sv
module mac_irq_linkmon #(
  parameter bit PRESENT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic link,
  output logic chg
);
  logic prev_q;

  // reset samples the live level so a steady link does not look like a change
  always_ff @(posedge clk) begin
    prev_q <= link;
    if (rst) prev_q <= link;
  end

  assign chg = PRESENT && !rst && (link != prev_q);
endmodule

// File: rtl/mac_irq_mmcsum.sv
module mac_irq_mmcsum #(
  parameter int MMC_W    = 8,
  parameter bit HAS_MMC  = 1'b1,
  parameter bit HAS_CSUM = 1'b1
) (
  input  logic [2:0][MMC_W-1:0] pend,
  output logic [2:0]            lvl,
  output logic                  sum
);
  localparam logic [2:0] GRP_ON = {HAS_MMC && HAS_CSUM, HAS_MMC, HAS_MMC};

  for (genvar g = 0; g < 3; g++) begin : g_grp
    assign lvl[g] = GRP_ON[g] & (|pend[g]);
  end

  assign sum = |lvl;
endmodule

// File: rtl/mac_irq_status.sv
module mac_irq_status
  import mac_irq_pkg::*;
#(
  parameter int ADDR_W                = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 'h38,
  parameter int GPI_N                 = 4,
  parameter int LPI_N                 = 4,
  parameter int TS_N                  = 3,
  parameter int MMC_W                 = 8,
  parameter bit HAS_GPI               = 1'b1,
  parameter bit HAS_LPI               = 1'b1,
  parameter bit HAS_TS                = 1'b1,
  parameter bit HAS_MMC               = 1'b1,
  parameter bit HAS_MMC_CSUM          = 1'b1,
  parameter bit HAS_PMT               = 1'b1,
  parameter bit HAS_PCS               = 1'b1,
  parameter bit HAS_PHYIF             = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic [GPI_N-1:0]  gpi_evt,
  input  logic [GPI_N-1:0]  gpi_en,
  input  logic              gpi_clr,
  input  logic [LPI_N-1:0]  lpi_evt,
  input  logic              lpi_clr,
  input  logic [TS_N-1:0]   ts_evt,
  input  logic              ts_clr,
  input  logic [MMC_W-1:0]  mmc_rx_pend,
  input  logic [MMC_W-1:0]  mmc_tx_pend,
  input  logic [MMC_W-1:0]  mmc_csum_pend,
  input  logic              pmt_magic,
  input  logic              pmt_wake,
  input  logic              pmt_clr,
  input  logic              an_done,
  input  logic              pcs_link_chg,
  input  logic              an_clr,
  input  logic              phy_link,
  input  logic              phy_clr,
  input  logic [11:0]       irq_mask,
  output logic              irq
);
  localparam logic [STAT_W-1:0] FEAT = feat_mask(HAS_GPI, HAS_LPI, HAS_TS, HAS_MMC,
                                                 HAS_MMC_CSUM, HAS_PMT, HAS_PCS, HAS_PHYIF);

  logic              gpi_f, lpi_f, ts_f, magic_f, wake_f, anc_f, lchg_f, phy_f;
  logic              link_chg;
  logic [2:0]        mmc_lvl;
  logic              mmc_sum;
  logic [STAT_W-1:0] stat_w;
  logic [31:0]       rd_data_q;
  logic              irq_q;

  mac_irq_sticky #(.SRC_W(GPI_N), .PRESENT(HAS_GPI)) u_gpi (
    .clk(clk), .rst(rst), .set_vec(gpi_evt & gpi_en), .clr(gpi_clr), .flag(gpi_f));

  mac_irq_sticky #(.SRC_W(LPI_N), .PRESENT(HAS_LPI)) u_lpi (
    .clk(clk), .rst(rst), .set_vec(lpi_evt), .clr(lpi_clr), .flag(lpi_f));

  mac_irq_sticky #(.SRC_W(TS_N), .PRESENT(HAS_TS)) u_ts (
    .clk(clk), .rst(rst), .set_vec(ts_evt), .clr(ts_clr), .flag(ts_f));

  mac_irq_sticky #(.SRC_W(1), .PRESENT(HAS_PMT)) u_magic (
    .clk(clk), .rst(rst), .set_vec(pmt_magic), .clr(pmt_clr), .flag(magic_f));

  mac_irq_sticky #(.SRC_W(1), .PRESENT(HAS_PMT)) u_wake (
    .clk(clk), .rst(rst), .set_vec(pmt_wake), .clr(pmt_clr), .flag(wake_f));

  mac_irq_sticky #(.SRC_W(1), .PRESENT(HAS_PCS)) u_anc (
    .clk(clk), .rst(rst), .set_vec(an_done), .clr(an_clr), .flag(anc_f));

  mac_irq_sticky #(.SRC_W(1), .PRESENT(HAS_PCS)) u_lchg (
    .clk(clk), .rst(rst), .set_vec(pcs_link_chg), .clr(an_clr), .flag(lchg_f));

  mac_irq_linkmon #(.PRESENT(HAS_PHYIF)) u_linkmon (
    .clk(clk), .rst(rst), .link(phy_link), .chg(link_chg));

  mac_irq_sticky #(.SRC_W(1), .PRESENT(HAS_PHYIF)) u_phy (
    .clk(clk), .rst(rst), .set_vec(link_chg), .clr(phy_clr), .flag(phy_f));

  mac_irq_mmcsum #(.MMC_W(MMC_W), .HAS_MMC(HAS_MMC), .HAS_CSUM(HAS_MMC_CSUM)) u_mmc (
    .pend({mmc_csum_pend, mmc_tx_pend, mmc_rx_pend}), .lvl(mmc_lvl), .sum(mmc_sum));

  always_comb begin
    stat_w          = '0;
    stat_w[B_GPI]   = gpi_f;
    stat_w[B_LPI]   = lpi_f;
    stat_w[B_TS]    = ts_f;
    stat_w[B_MCSUM] = mmc_lvl[2];
    stat_w[B_MTX]   = mmc_lvl[1];
    stat_w[B_MRX]   = mmc_lvl[0];
    stat_w[B_MSUM]  = mmc_sum;
    stat_w[B_PMT]   = magic_f | wake_f;
    stat_w[B_ANC]   = anc_f;
    stat_w[B_LCHG]  = lchg_f;
    stat_w[B_PHY]   = phy_f;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_q <= '0;
      irq_q     <= 1'b0;
    end else begin
      if (rd_en) rd_data_q <= (rd_addr == REG_OFS) ? stat_w : '0;
      irq_q <= |(stat_w[USED_W-1:0] & irq_mask);
    end
  end

  assign rd_data = rd_data_q;
  assign irq     = irq_q;
endmodule

// File: rtl/mac_irq_status_chk.sv
module mac_irq_status_chk #(
  parameter logic [31:0] FEAT = '1,
  parameter int GPI_N = 4,
  parameter int LPI_N = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_en,
  input logic [31:0]      rd_data,
  input logic             irq,
  input logic [31:0]      stat,
  input logic [GPI_N-1:0] gpi_evt,
  input logic [GPI_N-1:0] gpi_en,
  input logic             gpi_clr,
  input logic [LPI_N-1:0] lpi_evt,
  input logic             lpi_clr,
  input logic [11:0]      irq_mask
);
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_data[31:12] == '0 && !rd_data[8]); // R2
  AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (stat & ~FEAT) == '0); // R12
  AST_MMC_SUMMARY: assert property (@(posedge clk) disable iff (rst)
    stat[4] == (|stat[7:5])); // R6
  AST_GPI_HOLD: assert property (@(posedge clk) disable iff (rst)
    stat[11] && !gpi_clr |=> stat[11]); // R3
  AST_GPI_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    FEAT[11] && (|(gpi_evt & gpi_en)) |=> stat[11]); // R10
  AST_LPI_CLEAR: assert property (@(posedge clk) disable iff (rst)
    lpi_clr && !(|lpi_evt) |=> !stat[10]); // R4
  AST_READ_NO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    rd_en && stat[10] && !lpi_clr |=> stat[10]); // R11
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
    (|(stat[11:0] & irq_mask)) |=> irq); // R13
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(|(stat[11:0] & irq_mask)) |=> !irq); // R13
endmodule

bind mac_irq_status mac_irq_status_chk #(.FEAT(FEAT), .GPI_N(GPI_N), .LPI_N(LPI_N)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_data(rd_data), .irq(irq), .stat(stat_w),
  .gpi_evt(gpi_evt), .gpi_en(gpi_en), .gpi_clr(gpi_clr), .lpi_evt(lpi_evt),
  .lpi_clr(lpi_clr), .irq_mask(irq_mask));

// File: tb/mac_irq_status_test.sv
module mac_irq_status_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data, rd_data_l;
  logic [3:0]  gpi_evt = '0, gpi_en = 4'hF, lpi_evt = '0;
  logic [2:0]  ts_evt = '0;
  logic [7:0]  mmc_rx = '0, mmc_tx = '0, mmc_cs = '0;
  logic gpi_clr = 0, lpi_clr = 0, ts_clr = 0, pmt_magic = 0, pmt_wake = 0, pmt_clr = 0;
  logic an_done = 0, pcs_lchg = 0, an_clr = 0, phy_link = 0, phy_clr = 0;
  logic [11:0] irq_mask = '0;
  logic irq, irq_l;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mac_irq_status uut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .gpi_evt(gpi_evt), .gpi_en(gpi_en), .gpi_clr(gpi_clr), .lpi_evt(lpi_evt), .lpi_clr(lpi_clr),
    .ts_evt(ts_evt), .ts_clr(ts_clr), .mmc_rx_pend(mmc_rx), .mmc_tx_pend(mmc_tx),
    .mmc_csum_pend(mmc_cs), .pmt_magic(pmt_magic), .pmt_wake(pmt_wake), .pmt_clr(pmt_clr),
    .an_done(an_done), .pcs_link_chg(pcs_lchg), .an_clr(an_clr), .phy_link(phy_link),
    .phy_clr(phy_clr), .irq_mask(irq_mask), .irq(irq));

  mac_irq_status #(.HAS_MMC(1'b0), .HAS_PMT(1'b0), .HAS_PCS(1'b0)) uut_lean (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data_l),
    .gpi_evt(gpi_evt), .gpi_en(gpi_en), .gpi_clr(gpi_clr), .lpi_evt(lpi_evt), .lpi_clr(lpi_clr),
    .ts_evt(ts_evt), .ts_clr(ts_clr), .mmc_rx_pend(mmc_rx), .mmc_tx_pend(mmc_tx),
    .mmc_csum_pend(mmc_cs), .pmt_magic(pmt_magic), .pmt_wake(pmt_wake), .pmt_clr(pmt_clr),
    .an_done(an_done), .pcs_link_chg(pcs_lchg), .an_clr(an_clr), .phy_link(phy_link),
    .phy_clr(phy_clr), .irq_mask(irq_mask), .irq(irq_l));

  localparam logic [31:0] LEAN_KEEP = 32'h0000_0E01;

  // entry: [31:24] pulses {-,toggle link,pcs link chg,an done,magic,ts,lpi,gpi}
  //        [23:18] clears {phy,an,pmt,ts,lpi,gpi}, [17:15] mmc levels {csum,tx,rx}
  //        [11:0] expected status word
  localparam int NVEC = 15;
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h01, 6'h00, 3'b000, 3'b0, 12'h800},
    {8'h02, 6'h00, 3'b000, 3'b0, 12'hC00},
    {8'h04, 6'h00, 3'b000, 3'b0, 12'hE00},
    {8'h00, 6'h01, 3'b000, 3'b0, 12'h600},
    {8'h00, 6'h00, 3'b001, 3'b0, 12'h630},
    {8'h00, 6'h00, 3'b100, 3'b0, 12'h690},
    {8'h00, 6'h06, 3'b000, 3'b0, 12'h000},
    {8'h08, 6'h00, 3'b000, 3'b0, 12'h008},
    {8'h30, 6'h00, 3'b000, 3'b0, 12'h00E},
    {8'h40, 6'h00, 3'b000, 3'b0, 12'h00F},
    {8'h00, 6'h10, 3'b000, 3'b0, 12'h009},
    {8'h08, 6'h08, 3'b000, 3'b0, 12'h009},
    {8'h00, 6'h08, 3'b000, 3'b0, 12'h001},
    {8'h01, 6'h21, 3'b000, 3'b0, 12'h800},
    {8'h00, 6'h01, 3'b000, 3'b0, 12'h000}
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic release_pulses();
    gpi_evt = '0; lpi_evt = '0; ts_evt = '0; pmt_magic = 0; pmt_wake = 0;
    an_done = 0; pcs_lchg = 0;
    gpi_clr = 0; lpi_clr = 0; ts_clr = 0; pmt_clr = 0; an_clr = 0; phy_clr = 0;
  endtask

  task automatic step();
    @(negedge clk);
    release_pulses();
  endtask

  task automatic rd(input logic [7:0] a);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rd_data after reset", rd_data, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd(8'h38);
    check("R1 status read after reset", rd_data, 32'h0);

    // vector table walk: R3 R4 R5 R6 R7 R8 R9 R10, with R2 and R12 on every read
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] p;
      logic [5:0] c;
      logic [2:0] m;
      p = VEC[i][31:24]; c = VEC[i][23:18]; m = VEC[i][17:15];
      gpi_evt = p[0] ? 4'b0010 : 4'b0;
      lpi_evt = p[1] ? 4'b0100 : 4'b0;
      ts_evt  = p[2] ? 3'b010 : 3'b0;
      pmt_magic = p[3]; an_done = p[4]; pcs_lchg = p[5];
      if (p[6]) phy_link = ~phy_link;
      {phy_clr, an_clr, pmt_clr, ts_clr, lpi_clr, gpi_clr} = c;
      mmc_rx = m[0] ? 8'h01 : 8'h00;
      mmc_tx = m[1] ? 8'h01 : 8'h00;
      mmc_cs = m[2] ? 8'h04 : 8'h00;
      step();
      rd(8'h38);
      check($sformatf("R3-table step %0d full (R2 R10)", i), rd_data, {20'b0, VEC[i][11:0]});
      check($sformatf("R12 table step %0d lean", i), rd_data_l, {20'b0, VEC[i][11:0]} & LEAN_KEEP);
    end

    // R3 event with its enable low is ignored
    gpi_en = 4'b1110; gpi_evt = 4'b0001;
    step();
    gpi_en = 4'hF;
    rd(8'h38);
    check("R3 disabled gpi event", rd_data, 32'h0);

    // R5 auxiliary line, R2 wrong address, R11 repeated reads
    ts_evt = 3'b100;
    step();
    rd(8'h3C);
    check("R2 other address reads 0", rd_data, 32'h0);
    rd(8'h38);
    check("R5 aux snapshot sets bit 9", rd_data, 32'h200);
    rd(8'h38);
    check("R11 second read unchanged", rd_data, 32'h200);
    ts_clr = 1;
    step();
    rd(8'h38);
    check("R5 ts clear", rd_data, 32'h0);

    // R4 last lpi line
    lpi_evt = 4'b1000;
    step();
    rd(8'h38);
    check("R4 receiver exit line", rd_data, 32'h400);
    lpi_clr = 1;
    step();

    // R7 wake-up cause
    pmt_wake = 1;
    step();
    rd(8'h38);
    check("R7 wake frame full", rd_data, 32'h008);
    check("R12 wake frame lean", rd_data_l, 32'h0);
    pmt_clr = 1;
    step();
    rd(8'h38);
    check("R7 pmt clear", rd_data, 32'h0);

    // R6 top bit of a pending vector
    mmc_tx = 8'h80;
    @(negedge clk);
    rd(8'h38);
    check("R6 tx vector msb", rd_data, 32'h050);
    mmc_tx = 8'h00;
    @(negedge clk);
    rd(8'h38);
    check("R6 tx vector drained", rd_data, 32'h0);

    // R9 link falling
    phy_link = ~phy_link;
    @(negedge clk);
    rd(8'h38);
    check("R9 link change", rd_data, 32'h001);
    phy_clr = 1;
    step();
    rd(8'h38);
    check("R9 link steady after clear", rd_data, 32'h0);

    // R13 masking and latency
    irq_mask = 12'h800;
    lpi_evt = 4'b0001;
    step();
    @(negedge clk);
    check("R13 masked source no irq", {31'b0, irq}, 32'h0);
    gpi_evt = 4'b0001;
    step();
    check("R13 irq not before status", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R13 irq one cycle after status", {31'b0, irq}, 32'h1);
    gpi_clr = 1; lpi_clr = 1;
    step();
    @(negedge clk);
    check("R13 irq drops", {31'b0, irq}, 32'h0);

    // R12 absent feature does not interrupt
    irq_mask = 12'hFFF;
    an_done = 1;
    step();
    @(negedge clk);
    check("R8 an done irq full", {31'b0, irq}, 32'h1);
    check("R12 an done irq lean", {31'b0, irq_l}, 32'h0);
    an_clr = 1;
    step();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule